// File: doc/BRIEF.md
# Trace Capture Filter and Trigger

This block sits between a core's stream of trace records and a small on-chip trace store. Each record carries the program counter (PC) of the instruction that produced it and a data word. An address-window filter decides which records are kept. Only a valid record whose PC lies between a programmed low and high address, both bounds included, is written. A typical window covers one interrupt routine, so the finite store is not filled with unrelated history.

Capture begins when arm is pulsed. Until a trigger arrives, kept records go into a 64-entry circular store, and each new record overwrites the oldest one. A trigger input, such as a protection fault, ends the pre-trigger phase. The block then keeps a programmed number (0 to 63) of further filtered records and freezes. The history leading up to the event therefore survives. After the freeze, software reads the entries back oldest-first through an index port. The window, the post-trigger count and the arm pulse can all be changed between runs to refine what is captured.

Top module: `trace_capture`

## Requirements
- R1: After reset, busy_o and done_o are 0 and fill_o is 0. Records presented before the first arm_i pulse are not stored.
- R2: While capturing, a record is stored only when rec_valid_i is 1 and win_lo_i <= rec_pc_i <= win_hi_i (unsigned compare, both bounds inclusive). Each stored record increments fill_o.
- R3: Stored records go to consecutive store slots, wrapping modulo 64. Once 64 records are held, each new record overwrites the oldest. fill_o saturates at 64.
- R4: The first trig_i seen while busy in the pre-trigger phase samples post_cnt_i as N. A filtered record in that same cycle is still stored. Exactly N further filtered records are then stored. On the edge after the last of them (or after the trigger cycle when N = 0), done_o goes to 1 and busy_o goes to 0.
- R5: While done_o is 1, records and triggers are ignored. fill_o and the store contents stay unchanged.
- R6: An arm_i pulse, in any state, clears fill_o and done_o and sets busy_o on the next edge. The record presented in the arm cycle is not stored.
- R7: When rd_idx_i = k (with k < fill_o), rd_pc_o and rd_data_o show the k-th oldest stored record one clock later. This is slot k if fill_o < 64, or slot (write pointer + k) mod 64 once the store is full.
- R8: A trig_i seen during the post-trigger phase is ignored. It neither restarts nor changes the remaining post-trigger count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Pulse to clear pointers and start a capture run |
| win_lo_i | input | 32 | Filter window low address, inclusive |
| win_hi_i | input | 32 | Filter window high address, inclusive |
| post_cnt_i | input | 6 | Records to keep after the trigger |
| trig_i | input | 1 | Trigger event (e.g. fault) |
| rec_valid_i | input | 1 | Trace record present this cycle |
| rec_pc_i | input | 32 | PC carried by the record |
| rec_data_i | input | 32 | Data carried by the record |
| rd_idx_i | input | 6 | Readout index, 0 = oldest |
| rd_pc_o | output | 32 | PC of the read entry (one-cycle latency) |
| rd_data_o | output | 32 | Data of the read entry (one-cycle latency) |
| fill_o | output | 7 | Number of valid stored entries (0..64) |
| busy_o | output | 1 | Capture running |
| done_o | output | 1 | Capture frozen after trigger |

## Verification
A wrong write pointer or fill count shows up on fill_o on the first edge after the faulty store. It also shows up later as readout entries that appear in the wrong oldest-first order or at the wrong slots. A miscounted post-trigger counter moves the rise of done_o by at least one stored record. This is visible in the cycle after that record. A filter with a wrong bound either grows fill_o on an out-of-window PC or leaves it flat on a boundary PC, so the error appears one edge after the record.

// File: rtl/trace_pkg.sv
package trace_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_POST = 2'd2,
    ST_DONE = 2'd3
  } cap_state_e;
endpackage

// File: rtl/trace_filter.sv
module trace_filter #(
  parameter int ADDR_W = 32
) (
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  output logic              hit_o
);
  assign hit_o = valid_i && (pc_i >= lo_i) && (pc_i <= hi_i);
endmodule

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import trace_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DLY_W = 6,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int FILL_W = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              trig_i,
  input  logic              hit_i,
  input  logic [DLY_W-1:0]  post_cnt_i,
  output logic              we_o,
  output logic [PTR_W-1:0]  wr_ptr_o,
  output logic [FILL_W-1:0] fill_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [FILL_W-1:0] FULL = FILL_W'(DEPTH);

  cap_state_e       state_q;
  logic [DLY_W-1:0] rem_q;

  assign busy_o = (state_q == ST_PRE) || (state_q == ST_POST);
  assign done_o = (state_q == ST_DONE);
  assign we_o   = busy_o && hit_i && !arm_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      rem_q    <= '0;
      wr_ptr_o <= '0;
      fill_o   <= '0;
    end else if (arm_i) begin
      state_q  <= ST_PRE;
      rem_q    <= '0;
      wr_ptr_o <= '0;
      fill_o   <= '0;
    end else begin
      if (we_o) begin
        wr_ptr_o <= wr_ptr_o + 1'b1;
        if (fill_o != FULL) fill_o <= fill_o + 1'b1;
      end
      case (state_q)
        ST_PRE: if (trig_i) begin
          rem_q   <= post_cnt_i;
          state_q <= (post_cnt_i == '0) ? ST_DONE : ST_POST;
        end
        // trigger ignored here; only stored records count down
        ST_POST: if (hit_i) begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == DLY_W'(1)) state_q <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  a_r3_fill_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_o <= FULL);
  a_r2_no_store_no_growth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_o && !arm_i) |=> $stable(fill_o));
  a_r5_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !arm_i) |=> (done_o && $stable(fill_o) && $stable(wr_ptr_o)));
  a_r6_arm_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (fill_o == '0 && !done_o && busy_o));
  a_r4_done_from_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o));
endmodule

// File: rtl/trace_store.sv
module trace_store #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int FILL_W = PTR_W + 1,
  localparam int ENT_W  = ADDR_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  wr_ptr_i,
  input  logic [FILL_W-1:0] fill_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_pc_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rd_addr;

  // oldest entry sits at the write pointer once the ring has wrapped
  assign rd_addr = (fill_i == FILL_W'(DEPTH)) ? (wr_ptr_i + rd_idx_i) : rd_idx_i;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wr_ptr_i] <= {pc_i, data_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pc_o   <= '0;
      rd_data_o <= '0;
    end else begin
      {rd_pc_o, rd_data_o} <= mem[rd_addr];
    end
  end
endmodule

// File: rtl/trace_capture.sv
module trace_capture #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DLY_W  = 6,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int FILL_W = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic [ADDR_W-1:0] win_lo_i,
  input  logic [ADDR_W-1:0] win_hi_i,
  input  logic [DLY_W-1:0]  post_cnt_i,
  input  logic              trig_i,
  input  logic              rec_valid_i,
  input  logic [ADDR_W-1:0] rec_pc_i,
  input  logic [DATA_W-1:0] rec_data_i,
  input  logic [PTR_W-1:0]  rd_idx_i,
  output logic [ADDR_W-1:0] rd_pc_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [FILL_W-1:0] fill_o,
  output logic              busy_o,
  output logic              done_o
);
  logic             hit, we;
  logic [PTR_W-1:0] wr_ptr;

  trace_filter #(.ADDR_W(ADDR_W)) u_filt (
    .valid_i(rec_valid_i), .pc_i(rec_pc_i), .lo_i(win_lo_i), .hi_i(win_hi_i),
    .hit_o(hit)
  );

  trace_ctrl #(.DEPTH(DEPTH), .DLY_W(DLY_W)) u_ctrl (
    .clk_i, .rst_ni, .arm_i, .trig_i, .hit_i(hit), .post_cnt_i,
    .we_o(we), .wr_ptr_o(wr_ptr), .fill_o, .busy_o, .done_o
  );

  trace_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni, .we_i(we), .wr_ptr_i(wr_ptr), .fill_i(fill_o),
    .pc_i(rec_pc_i), .data_i(rec_data_i), .rd_idx_i, .rd_pc_o, .rd_data_o
  );

  a_r2_store_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |-> (rec_valid_i && rec_pc_i >= win_lo_i && rec_pc_i <= win_hi_i));
  a_r1_idle_no_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o) |-> !we);
endmodule

// File: tb/sim_trace_capture.sv
module sim_trace_capture;
  logic        clk = 0, rst_n = 0;
  logic        arm = 0, trig = 0, vld = 0;
  logic [31:0] lo = 0, hi = 0, pc = 0, dat = 0;
  logic [5:0]  post = 0, ridx = 0;
  logic [31:0] rpc, rdat;
  logic [6:0]  fill;
  logic        busy, done;

  always #2 clk = ~clk;

  trace_capture u0 (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .win_lo_i(lo), .win_hi_i(hi),
    .post_cnt_i(post), .trig_i(trig), .rec_valid_i(vld), .rec_pc_i(pc),
    .rec_data_i(dat), .rd_idx_i(ridx), .rd_pc_o(rpc), .rd_data_o(rdat),
    .fill_o(fill), .busy_o(busy), .done_o(done)
  );

  int checks = 0, errors = 0;
  bit ended = 0;

  int          m_st = 0, m_wp = 0, m_fill = 0, m_rem = 0;
  logic [31:0] m_pc [64];
  logic [31:0] m_dat [64];

  function automatic bit in_win(logic v, logic [31:0] p);
    return v && p >= lo && p <= hi;
  endfunction

  function automatic int old_slot(int k);
    return (m_fill == 64) ? (m_wp + k) % 64 : k;
  endfunction

  function void model_step();
    bit h;
    int st;
    st = m_st;
    if (arm) begin
      m_st = 1; m_wp = 0; m_fill = 0; m_rem = 0;
      return;
    end
    h = in_win(vld, pc) && (st == 1 || st == 2);
    if (h) begin
      m_pc[m_wp] = pc; m_dat[m_wp] = dat;
      m_wp = (m_wp + 1) % 64;
      if (m_fill < 64) m_fill++;
    end
    if (st == 1 && trig) begin
      m_rem = post;
      m_st = (post == 0) ? 3 : 2;
    end else if (st == 2 && h) begin
      if (m_rem == 1) m_st = 3;
      m_rem--;
    end
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(logic a, logic t, logic v, logic [31:0] p, logic [31:0] d);
    arm = a; trig = t; vld = v; pc = p; dat = d;
    model_step();
    @(negedge clk);
    arm = 0; trig = 0; vld = 0;
  endtask

  task automatic chk_state(string req);
    chk({req, " fill"}, 32'(fill), 32'(m_fill));
    chk({req, " busy"}, 32'(busy), 32'(m_st == 1 || m_st == 2));
    chk({req, " done"}, 32'(done), 32'(m_st == 3));
  endtask

  task automatic rand_rec(logic t);
    cyc(0, t, ($urandom_range(0, 3) != 0), $urandom_range(0, 'h2ff), $urandom);
  endtask

  task automatic read_all(string req);
    for (int k = 0; k < m_fill; k++) begin
      ridx = 6'(k);
      @(negedge clk);
      chk({req, " rd_pc"}, rpc, m_pc[old_slot(k)]);
      chk({req, " rd_data"}, rdat, m_dat[old_slot(k)]);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state, records before arm ignored
    chk_state("R1");
    lo = 0; hi = 32'hffff_ffff;
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 32'(i), 32'(i));
    chk_state("R1");

    // R6: arm; record in arm cycle not stored
    lo = 32'h100; hi = 32'h1ff; post = 6'd5;
    cyc(1, 0, 1, 32'h150, 32'hdead);
    chk_state("R6");
    // R2: inclusive bounds
    cyc(0, 0, 1, 32'h0ff, 32'h1); chk_state("R2");
    cyc(0, 0, 1, 32'h100, 32'h2); chk_state("R2");
    cyc(0, 0, 1, 32'h1ff, 32'h3); chk_state("R2");
    cyc(0, 0, 1, 32'h200, 32'h4); chk_state("R2");
    cyc(0, 0, 0, 32'h150, 32'h5); chk_state("R2");
    // R3: random traffic wraps the ring
    for (int i = 0; i < 300; i++) begin
      rand_rec(0);
      chk_state("R3");
    end
    chk("R3 saturate", 32'(fill), 32'd64);
    // R4: trigger then post-trigger records
    cyc(0, 1, 1, 32'h180, 32'hface);
    chk_state("R4");
    for (int i = 0; i < 200 && m_st != 3; i++) begin
      rand_rec(($urandom_range(0, 3) == 0));  // R8 stray triggers
      chk_state("R4");
    end
    chk("R4 done", 32'(done), 32'd1);
    read_all("R7");
    // R5: frozen after done
    for (int i = 0; i < 20; i++) begin
      cyc(0, 1, 1, 32'h1a0, $urandom);
      chk_state("R5");
    end
    read_all("R5");

    // R6: re-arm with new window; R4 with post = 0; R7 non-wrapped readout
    lo = 32'h40; hi = 32'h7f; post = 6'd0;
    cyc(1, 0, 0, 0, 0);
    chk_state("R6");
    for (int i = 0; i < 30; i++) begin
      rand_rec(0);
      chk_state("R6");
    end
    cyc(0, 1, 1, 32'h7f, 32'hbeef);
    chk_state("R4");
    chk("R4 zero post", 32'(done), 32'd1);
    read_all("R7");

    // R8: post = 3, triggers during post phase do not restart count
    lo = 32'h0; hi = 32'h2ff; post = 6'd3;
    cyc(1, 0, 0, 0, 0);
    for (int i = 0; i < 70; i++) cyc(0, 0, 1, 32'(i), 32'(i * 3));
    cyc(0, 1, 0, 0, 0); chk_state("R8");
    cyc(0, 0, 1, 32'h10, 32'ha); chk_state("R8");
    cyc(0, 1, 1, 32'h11, 32'hb); chk_state("R8");
    cyc(0, 1, 0, 32'h12, 32'hc); chk_state("R8");
    cyc(0, 0, 1, 32'h13, 32'hd); chk_state("R8");
    chk("R8 done after 3", 32'(done), 32'd1);
    read_all("R7");
    finish_run();
  end
endmodule